// File: doc/BRIEF.md
# Bit-Sliced Word ALU with Signed Compare

This block is a word-wide arithmetic and logic unit built from identical one-bit slices. Each slice takes one bit of each operand and can invert its B bit. It forms the AND, the OR and the full-adder sum of its bits, and a 2-bit select picks which of these, or a per-bit "less" input, becomes its result bit. The carry ripples from slice to slice.

The most significant position adds a small extension. It works out signed overflow and a "set" bit that gives the true sign of the difference. The set bit is routed back into the less input of bit 0, so a subtract-and-select-less operation yields 1 when A is below B as signed numbers and 0 otherwise. Subtraction inverts B and feeds a carry of 1 into bit 0. One control input, `neg_b`, does both.

The slice array itself is combinational. Its outputs are captured in one register stage, so every result appears one clock after its operands were presented.

Top module: `alu_slice_array`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next state is `res_q` = 0, `cout_q` = 0, `ovf_q` = 0, `zero_q` = 1.
- R2: Every output shows the function of the `op_a`, `op_b`, `neg_b` and `op_sel` values sampled at the previous rising edge (one cycle of latency).
- R3: `op_sel` = 0 gives `op_a & op_b` when `neg_b` = 0, and `op_a & ~op_b` when `neg_b` = 1.
- R4: `op_sel` = 1 gives `op_a | op_b` when `neg_b` = 0, and `op_a | ~op_b` when `neg_b` = 1.
- R5: `op_sel` = 2 with `neg_b` = 0 gives `op_a + op_b` modulo 2^WIDTH.
- R6: `op_sel` = 2 with `neg_b` = 1 gives `op_a - op_b` modulo 2^WIDTH. For any `op_sel`, `cout_q` is the carry out of the top bit of `op_a + (op_b ^ {WIDTH{neg_b}}) + neg_b`. With `neg_b` = 1 this is 1 exactly when `op_a >= op_b` unsigned.
- R7: For any `op_sel`, `ovf_q` is 1 exactly when that same adder sum overflows as a signed two's-complement number, that is, when the carry into the top bit differs from the carry out of it.
- R8: `op_sel` = 3 with `neg_b` = 1 gives a result whose bit 0 is 1 exactly when `op_a < op_b` signed, including operand pairs whose difference overflows. All other result bits are 0.
- R9: `op_sel` = 3 with `neg_b` = 0 gives a result whose bit 0 is 1 exactly when the signed sum `op_a + op_b`, taken without wrap, is negative. All other result bits are 0.
- R10: `zero_q` is 1 exactly when all bits of `res_q` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_a | input | WIDTH | Operand A |
| op_b | input | WIDTH | Operand B |
| neg_b | input | 1 | Invert B and inject carry 1 into bit 0 |
| op_sel | input | 2 | Function: 0 AND, 1 OR, 2 sum, 3 less |
| res_q | output | WIDTH | Registered result |
| cout_q | output | 1 | Registered carry out of the top slice |
| ovf_q | output | 1 | Registered signed overflow |
| zero_q | output | 1 | Registered all-zero result flag |

## Verification
The hardest case to reach is a signed compare whose subtraction overflows. Only then does the set bit differ from the raw sign of the difference. Random operands produce it rarely for some sign pairs, so directed vectors place opposite-sign extremes (most negative against positive, most positive against negative one) under the less and sum selects. Random vectors with a fixed seed then cover the other operand and select mixes, and some of them force equal operands so that the zero flag gets exercised.

// File: rtl/alu_slice_pkg.sv
// Package: shared function-select encoding for the bit-sliced ALU.
// Assumes the select field is two bits wide; the encodings are decoded by
// every slice and must not be reordered.
package alu_slice_pkg;

    typedef enum logic [1:0] {
        FN_AND  = 2'd0,
        FN_OR   = 2'd1,
        FN_SUM  = 2'd2,
        FN_LESS = 2'd3
    } alu_fn_e;

endpackage

// File: rtl/alu_bit_slice.sv
// Module: one bit of the ALU. It optionally inverts its B bit, forms AND, OR
// and the full-adder sum, and selects among those and the less input.
// Assumes carry_i arrives from the slice below (or the word carry-in).
module alu_bit_slice
    import alu_slice_pkg::*;
(
    input  logic    a_i,
    input  logic    b_i,
    input  logic    carry_i,
    input  logic    inv_i,
    input  logic    less_i,
    input  alu_fn_e fn_i,
    output logic    res_o,
    output logic    sum_o,
    output logic    carry_o
);

    logic b_eff;

    // Conditioned B bit, full-adder sum and majority carry.
    always_comb begin
        b_eff   = b_i ^ inv_i;
        sum_o   = a_i ^ b_eff ^ carry_i;
        carry_o = (a_i & b_eff) | (a_i & carry_i) | (b_eff & carry_i);
    end

    // Result selection by function code.
    always_comb begin
        unique case (fn_i)
            FN_AND:  res_o = a_i & b_eff;
            FN_OR:   res_o = a_i | b_eff;
            FN_SUM:  res_o = sum_o;
            default: res_o = less_i;
        endcase
    end

endmodule

// File: rtl/alu_msb_ext.sv
// Module: top-position extension. It derives signed overflow from the carries
// around the top slice, and the set bit (true sign of the sum).
// Assumes sum_i, carry_in_i and carry_out_i all belong to the top slice.
module alu_msb_ext (
    input  logic sum_i,
    input  logic carry_in_i,
    input  logic carry_out_i,
    output logic ovf_o,
    output logic set_o
);

    // Overflow when the carries around the top bit disagree; the set bit
    // corrects the sign for an overflowed sum.
    always_comb begin
        ovf_o = carry_in_i ^ carry_out_i;
        set_o = sum_i ^ ovf_o;
    end

endmodule

// File: rtl/alu_slice_array.sv
// Module: word ALU of WIDTH replicated slices with ripple carry. The set bit
// of the top position feeds the less input of bit 0, and the outputs are
// registered. Assumes WIDTH >= 2 and a synchronous active-low reset.
module alu_slice_array
    import alu_slice_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             neg_b,
    input  logic [1:0]       op_sel,
    output logic [WIDTH-1:0] res_q,
    output logic             cout_q,
    output logic             ovf_q,
    output logic             zero_q
);

    localparam int TOP = WIDTH - 1;

    alu_fn_e          fn;
    logic             carry [0:WIDTH];
    logic [WIDTH-1:0] res_c;
    logic [WIDTH-1:0] sum_c;
    logic             set_c;
    logic             ovf_c;

    // Function code cast and word carry-in.
    always_comb begin
        fn       = alu_fn_e'(op_sel);
        carry[0] = neg_b;
    end

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_slice
            logic less_bit;
            if (i == 0) begin : g_lsb
                // Bit 0 takes the set feedback.
                always_comb less_bit = set_c;
            end else begin : g_upper
                // Upper bits never pass anything but zero.
                always_comb less_bit = 1'b0;
            end
            alu_bit_slice u_slice (
                .a_i     (op_a[i]),
                .b_i     (op_b[i]),
                .carry_i (carry[i]),
                .inv_i   (neg_b),
                .less_i  (less_bit),
                .fn_i    (fn),
                .res_o   (res_c[i]),
                .sum_o   (sum_c[i]),
                .carry_o (carry[i+1])
            );
        end
    endgenerate

    alu_msb_ext u_msb (
        .sum_i       (sum_c[TOP]),
        .carry_in_i  (carry[TOP]),
        .carry_out_i (carry[WIDTH]),
        .ovf_o       (ovf_c),
        .set_o       (set_c)
    );

    // Output register stage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q  <= '0;
            cout_q <= 1'b0;
            ovf_q  <= 1'b0;
            zero_q <= 1'b1;
        end else begin
            res_q  <= res_c;
            cout_q <= carry[WIDTH];
            ovf_q  <= ovf_c;
            zero_q <= (res_c == '0);
        end
    end

endmodule

// File: rtl/alu_slice_array_chk.sv
// Module: property checker for alu_slice_array, attached by bind.
// Assumes it sees the top module's ports under their own names.
module alu_slice_array_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic             neg_b,
    input logic [1:0]       op_sel,
    input logic [WIDTH-1:0] res_q,
    input logic             cout_q,
    input logic             ovf_q,
    input logic             zero_q
);

    // R10
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (zero_q == (res_q == '0)));

    // R3
    and_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel) == 2'd0 && !$past(neg_b))
            |-> res_q == ($past(op_a) & $past(op_b)));

    // R8
    less_upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel) == 2'd3)
            |-> res_q[WIDTH-1:1] == '0);

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(neg_b)
            && ($past(op_a[WIDTH-1]) != $past(op_b[WIDTH-1]))) |-> !ovf_q);

    // R6
    sub_equal_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(neg_b) && ($past(op_a) == $past(op_b)))
            |-> (cout_q && !ovf_q));

endmodule

bind alu_slice_array alu_slice_array_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_alu_slice_array.sv
module sim_alu_slice_array;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         neg_b = 1'b0;
    logic [1:0]   op_sel = 2'd0;
    logic [W-1:0] res_q;
    logic         cout_q;
    logic         ovf_q;
    logic         zero_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    alu_slice_array #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .neg_b(neg_b),
        .op_sel(op_sel), .res_q(res_q), .cout_q(cout_q), .ovf_q(ovf_q),
        .zero_q(zero_q)
    );

    always #2 clk = ~clk;

    // Reference adder: {carry out, sum} of a + (b ^ inv) + inv.
    function automatic logic [W:0] ref_sum(logic [W-1:0] a, logic [W-1:0] b, logic inv);
        logic [W-1:0] bb;
        bb = b ^ {W{inv}};
        return {1'b0, a} + {1'b0, bb} + {{W{1'b0}}, inv};
    endfunction

    // Signed overflow of the same adder, judged from the operand and sum signs.
    function automatic logic ref_ovf(logic [W-1:0] a, logic [W-1:0] b, logic inv);
        logic [W-1:0] bb;
        logic [W:0]   s;
        bb = b ^ {W{inv}};
        s  = ref_sum(a, b, inv);
        return (a[W-1] == bb[W-1]) && (s[W-1] != a[W-1]);
    endfunction

    // Expected result for each function code.
    function automatic logic [W-1:0] ref_res(logic [W-1:0] a, logic [W-1:0] b,
                                             logic inv, logic [1:0] sel);
        logic [W-1:0] bb;
        logic signed [W:0] wide;
        bb = b ^ {W{inv}};
        case (sel)
            2'd0: return a & bb;
            2'd1: return a | bb;
            2'd2: return ref_sum(a, b, inv);
            default: begin
                if (inv) wide = $signed({a[W-1], a}) - $signed({b[W-1], b});
                else     wide = $signed({a[W-1], a}) + $signed({b[W-1], b});
                return {{(W-1){1'b0}}, wide[W]};
            end
        endcase
    endfunction

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one vector on the falling edge, then check after the capturing edge.
    task automatic apply(logic [W-1:0] a, logic [W-1:0] b, logic inv, logic [1:0] sel);
        logic [W-1:0] er;
        logic [W:0]   es;
        string        tag;
        op_a = a; op_b = b; neg_b = inv; op_sel = sel;
        @(negedge clk);
        er = ref_res(a, b, inv, sel);
        es = ref_sum(a, b, inv);
        case (sel)
            2'd0: tag = "R3 and (R2 latency)";
            2'd1: tag = "R4 or";
            2'd2: tag = inv ? "R6 subtract" : "R5 add";
            default: tag = inv ? "R8 signed less" : "R9 sum sign";
        endcase
        check(tag, res_q, er);
        check("R6 carry out", {{(W-1){1'b0}}, cout_q}, {{(W-1){1'b0}}, es[W]});
        check("R7 overflow", {{(W-1){1'b0}}, ovf_q}, {{(W-1){1'b0}}, ref_ovf(a, b, inv)});
        check("R10 zero flag", {{(W-1){1'b0}}, zero_q}, {{(W-1){1'b0}}, er == '0});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        op_a = 8'hA5; op_b = 8'h3C;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 reset res", res_q, '0);
        check("R1 reset flags", {{(W-3){1'b0}}, cout_q, ovf_q, zero_q}, 8'b001);
        rst_n = 1'b1;

        // Directed corner cases.
        apply(8'hFF, 8'h01, 1'b0, 2'd2);   // R5 wrap with carry out
        apply(8'h7F, 8'h01, 1'b0, 2'd2);   // R7 positive overflow
        apply(8'h80, 8'h01, 1'b1, 2'd2);   // R6 subtract overflow
        apply(8'h80, 8'h01, 1'b1, 2'd3);   // R8 -128 < 1 with overflow
        apply(8'h7F, 8'hFF, 1'b1, 2'd3);   // R8 127 < -1 false, overflow
        apply(8'h05, 8'h05, 1'b1, 2'd3);   // R8 equal -> 0
        apply(8'h05, 8'h05, 1'b1, 2'd2);   // R10 zero difference
        apply(8'h80, 8'h80, 1'b0, 2'd3);   // R9 -256 negative
        apply(8'h7F, 8'h7F, 1'b0, 2'd3);   // R9 254 positive
        apply(8'hF0, 8'h3C, 1'b1, 2'd0);   // R3 a & ~b
        apply(8'h0F, 8'h0F, 1'b1, 2'd1);   // R4 a | ~b
        apply(8'h00, 8'h00, 1'b0, 2'd1);   // R10 zero from OR

        // Constrained random vectors.
        for (int i = 0; i < 400; i++) begin
            logic [W-1:0] a;
            logic [W-1:0] b;
            a = W'($urandom);
            b = ($urandom_range(0, 7) == 0) ? a : W'($urandom);
            apply(a, b, 1'(($urandom)), 2'($urandom));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule